// File: doc/BRIEF.md
# Occupancy-Limited Thread-Block Dispatcher

This block hands the thread blocks (CTAs) of one kernel to a group of shader cores. Software presents a kernel descriptor with a CTA count and the registers and shared memory that each CTA needs, then pulses `start`. From then on the dispatcher offers CTAs one at a time on a valid/ready handshake. Each offer names the CTA index and the core that should take it. The cores report each finished CTA with a one-cycle pulse on their own `cta_done` line.

Each core can hold a limited number of CTAs at once. That limit is the smallest of three values: the core's register total divided by the registers per CTA, the core's shared-memory total divided by the shared memory per CTA, and a throttle value that software sets. The throttle bounds the number of active warps, which is the throttle times the warps per CTA, so software can tune the multithreading degree of later dispatch rounds without touching the kernel. When no core has room for even one CTA, the block flags an error and dispatches nothing. Once every CTA has been handed out and has finished, it raises a done flag.

Top module: `cta_dispatch_top`

## Requirements
- R1: After reset, `disp_valid`, `kernel_done` and `kernel_err` are low and no CTA is offered until `start` is seen.
- R2: A core's register limit is its register total divided by `kern_regs_per_cta`, rounded down and capped at 8. A per-CTA need of zero places no register limit on the core.
- R3: A core's shared-memory limit is derived from `kern_smem_per_cta` in the same way. A core whose limit is zero is never chosen.
- R4: The limit is further capped by `throttle_slots`, where values above 8 count as 8. The throttle is read every cycle. Lowering it never evicts resident CTAs, but it blocks refills until the resident count falls below the new value.
- R5: A core is eligible while its resident count is below its limit. `disp_valid` is high exactly when a kernel is running, CTAs remain undispatched, and at least one core is eligible.
- R6: A `cta_done` pulse lowers that core's resident count in the same cycle, so a full core can receive a new CTA in the cycle of its completion pulse.
- R7: Among eligible cores, `disp_core` is the first one found searching upward, with wrap-around, from the core after the one most recently served. After reset that search starts at core 0.
- R8: CTA indices are offered as 0, 1, 2, … up to the CTA count minus one. The index advances only on a cycle with `disp_valid` and `disp_ready` both high.
- R9: `kernel_done` rises one cycle after all CTAs have been dispatched and the number of completion pulses has reached the CTA count. It stays high until the next `start`. A count of zero finishes at once.
- R10: If the CTA count is nonzero and the resource limit (R2 and R3, ignoring the throttle) is zero on every core, `kernel_err` rises in the second cycle after `start` and nothing is offered.
- R11: `start` is taken only while no kernel is running. A `start` pulse in the middle of a kernel has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Latch the descriptor and begin a kernel |
| kern_num_ctas | input | 16 | Number of CTAs in the kernel |
| kern_regs_per_cta | input | 16 | Registers needed per CTA |
| kern_smem_per_cta | input | 16 | Shared memory units needed per CTA |
| throttle_slots | input | 4 | Software cap on resident CTAs per core |
| core_reg_total | input | 64 | Register total of each core, 16 bits per core, core 0 lowest |
| core_smem_total | input | 64 | Shared-memory total of each core, 16 bits per core |
| cta_done | input | 4 | One-cycle completion pulse per core |
| disp_valid | output | 1 | A CTA is offered |
| disp_ready | input | 1 | The offered CTA is accepted |
| disp_cta_idx | output | 16 | Index of the offered CTA |
| disp_core | output | 2 | Core chosen for the offered CTA |
| kernel_done | output | 1 | All CTAs dispatched and completed |
| kernel_err | output | 1 | No core can hold a single CTA |

## Verification
The coincidence that matters is a completion pulse arriving at a full core in the same cycle as a dispatch decision. The freed slot must be offered within that cycle, and the resident count must net out to unchanged. The bench provokes this case directly: it fills every core to its register limit, then pulses completion on one core with `disp_ready` high and expects that core to be named in that cycle. Random phases then let completions, stalls and throttle changes overlap freely. A behavioural model checks the valid, core, index, done and error outputs on every clock.

// File: rtl/cta_disp_pkg.sv
package cta_disp_pkg;

    parameter int unsigned NUM_CORES = 4;
    parameter int unsigned CTA_W     = 16;
    parameter int unsigned RES_W     = 16;
    parameter int unsigned MAX_SLOTS = 8;

    localparam int unsigned SLOT_W = $clog2(MAX_SLOTS + 1);
    localparam int unsigned CORE_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1;
    localparam int unsigned CNT_W  = $clog2(NUM_CORES + 1);

    typedef logic [SLOT_W-1:0] slot_t;
    typedef logic [CTA_W-1:0]  cta_idx_t;
    typedef logic [RES_W-1:0]  res_t;
    typedef logic [CORE_W-1:0] core_id_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_ERR,
        ST_DONE
    } disp_state_e;

    typedef struct packed {
        cta_idx_t num_ctas;
        res_t     regs_per_cta;
        res_t     smem_per_cta;
    } kernel_desc_t;

    function automatic slot_t cap_res(input res_t v);
        if (v >= res_t'(MAX_SLOTS)) return slot_t'(MAX_SLOTS);
        return slot_t'(v);
    endfunction

    function automatic slot_t cap_slot(input slot_t v);
        if (v >= slot_t'(MAX_SLOTS)) return slot_t'(MAX_SLOTS);
        return v;
    endfunction

    function automatic slot_t min_slot(input slot_t a, input slot_t b);
        return (a < b) ? a : b;
    endfunction

endpackage

// File: rtl/cta_occupancy.sv
module cta_occupancy
    import cta_disp_pkg::*;
(
    input  res_t  reg_total,
    input  res_t  smem_total,
    input  res_t  regs_per_cta,
    input  res_t  smem_per_cta,
    input  slot_t throttle,
    output slot_t res_limit,
    output slot_t limit
);
    res_t  reg_div, smem_div;
    slot_t reg_lim, smem_lim;

    always_comb begin
        reg_div  = (regs_per_cta == '0) ? res_t'(1) : regs_per_cta;
        smem_div = (smem_per_cta == '0) ? res_t'(1) : smem_per_cta;
        reg_lim  = (regs_per_cta == '0) ? slot_t'(MAX_SLOTS) : cap_res(reg_total / reg_div);
        smem_lim = (smem_per_cta == '0) ? slot_t'(MAX_SLOTS) : cap_res(smem_total / smem_div);
        res_limit = min_slot(reg_lim, smem_lim);
        limit     = min_slot(res_limit, cap_slot(throttle));
    end

    always_comb begin
        assert (limit <= res_limit);
    end
endmodule

// File: rtl/cta_core_tracker.sv
module cta_core_tracker
    import cta_disp_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  inc,
    input  logic  dec,
    input  slot_t limit,
    output logic  eligible,
    output slot_t count
);
    slot_t after_done;

    always_comb begin
        after_done = count - slot_t'(dec);
        eligible   = after_done < limit;
    end

    always_ff @(posedge clk) begin
        if (rst) count <= '0;
        else     count <= count + slot_t'(inc) - slot_t'(dec);
    end

    AST_FIRE_ONLY_ELIGIBLE: assert property (@(posedge clk) disable iff (rst)
        inc |-> eligible); // R5
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        count <= slot_t'(MAX_SLOTS)); // R5
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        dec |-> (count != '0)); // R6
endmodule

// File: rtl/cta_rr_arbiter.sv
module cta_rr_arbiter #(
    parameter int unsigned N = 4,
    parameter int unsigned W = (N > 1) ? $clog2(N) : 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] req,
    input  logic         advance,
    output logic [W-1:0] grant,
    output logic         any
);
    logic [W-1:0] last;

    always_comb begin
        grant = '0;
        any   = 1'b0;
        for (int off = 1; off <= int'(N); off++) begin
            if (!any && req[(int'(last) + off) % int'(N)]) begin
                any   = 1'b1;
                grant = W'((int'(last) + off) % int'(N));
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)          last <= W'(N - 1);
        else if (advance) last <= grant;
    end

    AST_GRANT_REQUESTED: assert property (@(posedge clk) disable iff (rst)
        any |-> req[grant]); // R7
    AST_ANY_MATCHES_REQ: assert property (@(posedge clk) disable iff (rst)
        any == (req != '0)); // R7
endmodule

// File: rtl/cta_dispatch_top.sv
module cta_dispatch_top
    import cta_disp_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       start,
    input  logic [CTA_W-1:0]           kern_num_ctas,
    input  logic [RES_W-1:0]           kern_regs_per_cta,
    input  logic [RES_W-1:0]           kern_smem_per_cta,
    input  logic [SLOT_W-1:0]          throttle_slots,
    input  logic [NUM_CORES*RES_W-1:0] core_reg_total,
    input  logic [NUM_CORES*RES_W-1:0] core_smem_total,
    input  logic [NUM_CORES-1:0]       cta_done,
    output logic                       disp_valid,
    input  logic                       disp_ready,
    output logic [CTA_W-1:0]           disp_cta_idx,
    output logic [CORE_W-1:0]          disp_core,
    output logic                       kernel_done,
    output logic                       kernel_err
);
    disp_state_e  state;
    kernel_desc_t desc;
    cta_idx_t     next_idx, completed;
    logic [NUM_CORES-1:0] eligible, inc, res_zero;
    slot_t        limit     [NUM_CORES];
    slot_t        res_limit [NUM_CORES];
    slot_t        count     [NUM_CORES];
    logic         any_elig, fire, running, all_sent, all_zero;
    logic [CNT_W-1:0] done_cnt;

    genvar g;
    generate
        for (g = 0; g < int'(NUM_CORES); g++) begin : g_core
            cta_occupancy u_occ (
                .reg_total    (core_reg_total[g*RES_W +: RES_W]),
                .smem_total   (core_smem_total[g*RES_W +: RES_W]),
                .regs_per_cta (desc.regs_per_cta),
                .smem_per_cta (desc.smem_per_cta),
                .throttle     (throttle_slots),
                .res_limit    (res_limit[g]),
                .limit        (limit[g])
            );
            assign res_zero[g] = (res_limit[g] == '0);
            assign inc[g]      = fire && (disp_core == core_id_t'(g));
            cta_core_tracker u_trk (
                .clk      (clk),
                .rst      (rst),
                .inc      (inc[g]),
                .dec      (cta_done[g]),
                .limit    (limit[g]),
                .eligible (eligible[g]),
                .count    (count[g])
            );
        end
    endgenerate

    cta_rr_arbiter #(.N(NUM_CORES), .W(CORE_W)) u_arb (
        .clk     (clk),
        .rst     (rst),
        .req     (eligible),
        .advance (fire),
        .grant   (disp_core),
        .any     (any_elig)
    );

    always_comb begin
        done_cnt = '0;
        for (int i = 0; i < int'(NUM_CORES); i++)
            done_cnt = done_cnt + CNT_W'(cta_done[i]);
    end

    assign running      = (state == ST_RUN);
    assign all_sent     = (next_idx == desc.num_ctas);
    assign all_zero     = &res_zero;
    assign disp_valid   = running && !all_sent && any_elig;
    assign fire         = disp_valid && disp_ready;
    assign disp_cta_idx = next_idx;
    assign kernel_done  = (state == ST_DONE);
    assign kernel_err   = (state == ST_ERR);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            desc      <= '0;
            next_idx  <= '0;
            completed <= '0;
        end else if (!running) begin
            if (start) begin
                desc.num_ctas     <= kern_num_ctas;
                desc.regs_per_cta <= kern_regs_per_cta;
                desc.smem_per_cta <= kern_smem_per_cta;
                next_idx          <= '0;
                completed         <= '0;
                state             <= ST_RUN;
            end
        end else begin
            if (all_sent && completed == desc.num_ctas)
                state <= ST_DONE;
            else if (desc.num_ctas != '0 && all_zero)
                state <= ST_ERR;
            if (fire) next_idx <= next_idx + cta_idx_t'(1);
            completed <= completed + cta_idx_t'(done_cnt);
        end
    end

    AST_IDX_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        fire |=> (next_idx == $past(next_idx) + cta_idx_t'(1))); // R8
    AST_IDX_HOLD: assert property (@(posedge clk) disable iff (rst)
        (running && !fire) |=> (next_idx == $past(next_idx))); // R8
    AST_NO_OFFER_IN_ERR: assert property (@(posedge clk) disable iff (rst)
        kernel_err |-> !disp_valid); // R10
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
        (kernel_done && !start) |=> kernel_done); // R9
    AST_NO_DONE_EARLY: assert property (@(posedge clk) disable iff (rst)
        $rose(kernel_done) |-> (next_idx == desc.num_ctas)); // R9
    AST_VALID_NEEDS_ROOM: assert property (@(posedge clk) disable iff (rst)
        disp_valid |-> (count[disp_core] - slot_t'(cta_done[disp_core]) < limit[disp_core])); // R5
endmodule

// File: tb/cta_dispatch_top_bench.sv
module cta_dispatch_top_bench;
    import cta_disp_pkg::*;

    localparam int NC = NUM_CORES;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [CTA_W-1:0] kern_num_ctas = '0;
    logic [RES_W-1:0] kern_regs_per_cta = '0, kern_smem_per_cta = '0;
    logic [SLOT_W-1:0] throttle_slots = SLOT_W'(8);
    logic [NC*RES_W-1:0] core_reg_total = '0, core_smem_total = '0;
    logic [NC-1:0] cta_done = '0;
    logic disp_valid, disp_ready = 1'b0;
    logic [CTA_W-1:0] disp_cta_idx;
    logic [CORE_W-1:0] disp_core;
    logic kernel_done, kernel_err;

    always #2 clk = ~clk;

    cta_dispatch_top u_cta_dispatch_top (
        .clk(clk), .rst(rst), .start(start),
        .kern_num_ctas(kern_num_ctas), .kern_regs_per_cta(kern_regs_per_cta),
        .kern_smem_per_cta(kern_smem_per_cta), .throttle_slots(throttle_slots),
        .core_reg_total(core_reg_total), .core_smem_total(core_smem_total),
        .cta_done(cta_done), .disp_valid(disp_valid), .disp_ready(disp_ready),
        .disp_cta_idx(disp_cta_idx), .disp_core(disp_core),
        .kernel_done(kernel_done), .kernel_err(kernel_err));

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    // behavioural model: 0 idle, 1 run, 2 err, 3 done
    int mst = 0, mlast = NC - 1, mnext = 0, mcomp = 0, mN = 0, mregs = 0, msmem = 0;
    int mres[NC];
    int regt[NC], smt[NC];
    bit s_valid; int s_core; int fires;

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int lim_of(int i, bit with_thr);
        int r, s, t, m;
        r = (mregs == 0) ? 8 : regt[i] / mregs; if (r > 8) r = 8;
        s = (msmem == 0) ? 8 : smt[i] / msmem;  if (s > 8) s = 8;
        m = (r < s) ? r : s;
        t = int'(throttle_slots); if (t > 8) t = 8;
        if (with_thr && t < m) m = t;
        return m;
    endfunction

    task automatic drive_totals();
        for (int i = 0; i < NC; i++) begin
            core_reg_total[i*RES_W +: RES_W]  = RES_W'(regt[i]);
            core_smem_total[i*RES_W +: RES_W] = RES_W'(smt[i]);
        end
    endtask

    task automatic step();
        bit el[NC]; bit anyel; int g; bit ev; bit allz; int pc; int nst;
        #1;
        anyel = 0; g = 0; allz = 1;
        for (int i = 0; i < NC; i++) begin
            el[i] = (mst == 1) && ((mres[i] - int'(cta_done[i])) < lim_of(i, 1));
            if (lim_of(i, 0) != 0) allz = 0;
        end
        for (int off = 1; off <= NC; off++)
            if (!anyel && el[(mlast + off) % NC]) begin anyel = 1; g = (mlast + off) % NC; end
        ev = (mst == 1) && (mnext < mN) && anyel;
        s_valid = disp_valid; s_core = int'(disp_core);
        chk(disp_valid == ev, "R5", "disp_valid", disp_valid, ev);
        if (ev && disp_valid) begin
            chk(int'(disp_core) == g, "R7", "disp_core", disp_core, g);
            chk(int'(disp_cta_idx) == mnext, "R8", "disp_cta_idx", disp_cta_idx, mnext);
        end
        chk(kernel_done == (mst == 3), "R9", "kernel_done", kernel_done, mst == 3);
        chk(kernel_err == (mst == 2), "R10", "kernel_err", kernel_err, mst == 2);
        if (ev && disp_ready) fires++;
        // model update
        if (mst != 1) begin
            if (start) begin
                mst = 1; mN = int'(kern_num_ctas); mregs = int'(kern_regs_per_cta);
                msmem = int'(kern_smem_per_cta); mnext = 0; mcomp = 0;
            end
        end else begin
            nst = 1;
            if (mnext == mN && mcomp == mN) nst = 3;
            else if (mN != 0 && allz) nst = 2;
            pc = 0;
            for (int i = 0; i < NC; i++) pc += int'(cta_done[i]);
            for (int i = 0; i < NC; i++)
                mres[i] += ((ev && disp_ready && g == i) ? 1 : 0) - int'(cta_done[i]);
            if (ev && disp_ready) begin mnext++; mlast = g; end
            mcomp += pc;
            mst = nst;
        end
        @(posedge clk); @(negedge clk);
    endtask

    task automatic launch(int n, int regs, int smem);
        kern_num_ctas = CTA_W'(n); kern_regs_per_cta = RES_W'(regs);
        kern_smem_per_cta = RES_W'(smem); start = 1; cta_done = '0; disp_ready = 0;
        step();
        start = 0;
    endtask

    task automatic idle_fill(int cycles);
        cta_done = '0; disp_ready = 1;
        for (int c = 0; c < cycles; c++) step();
    endtask

    task automatic random_run(int cycles, bit stop_at_done);
        for (int c = 0; c < cycles; c++) begin
            if (stop_at_done && mst != 1) break;
            disp_ready = ($urandom % 4) != 0;
            for (int i = 0; i < NC; i++)
                cta_done[i] = (mres[i] > 0) && (($urandom % 3) == 0);
            step();
        end
        cta_done = '0; disp_ready = 0;
    endtask

    initial begin
        for (int i = 0; i < NC; i++) mres[i] = 0;
        @(negedge clk); @(negedge clk);
        rst = 0;
        // R1: reset state
        chk(disp_valid == 0, "R1", "disp_valid after reset", disp_valid, 0);
        chk(kernel_done == 0, "R1", "kernel_done after reset", kernel_done, 0);
        chk(kernel_err == 0, "R1", "kernel_err after reset", kernel_err, 0);
        disp_ready = 1;
        step(); step();

        // Scenario A: register limit 60/20 = 3 per core
        for (int i = 0; i < NC; i++) begin regt[i] = 60; smt[i] = 1000; end
        throttle_slots = SLOT_W'(8); drive_totals();
        launch(20, 20, 10);
        fires = 0;
        idle_fill(20);
        chk(fires == 3 * NC, "R2", "dispatches with no completions", fires, 3 * NC);
        // R6: full core freed and refilled in the same cycle
        cta_done = '0; cta_done[2] = 1'b1; disp_ready = 1;
        step();
        chk(s_valid == 1 && s_core == 2, "R6", "same-cycle refill core", s_core, 2);
        cta_done = '0;
        fires = 3 * NC + 1;
        random_run(3000, 1);
        step();
        chk(kernel_done == 1, "R9", "done after scenario A", kernel_done, 1);
        chk(fires == 20, "R8", "total dispatched A", fires, 20);

        // Scenario B: shared-memory limit 5,2,1,0; no register limit
        smt[0] = 100; smt[1] = 50; smt[2] = 30; smt[3] = 10;
        for (int i = 0; i < NC; i++) regt[i] = 0;
        drive_totals();
        launch(30, 0, 20);
        fires = 0;
        idle_fill(20);
        chk(fires == 8, "R3", "dispatches limited by shared memory", fires, 8);
        chk(mres[3] == 0, "R3", "zero-limit core untouched", mres[3], 0);
        random_run(4000, 1);
        step();
        chk(kernel_done == 1, "R9", "done after scenario B", kernel_done, 1);

        // Scenario C: throttle
        for (int i = 0; i < NC; i++) begin regt[i] = 1000; smt[i] = 1000; end
        drive_totals(); throttle_slots = SLOT_W'(2);
        launch(40, 10, 10);
        fires = 0;
        idle_fill(12);
        chk(fires == 2 * NC, "R4", "dispatches under throttle 2", fires, 2 * NC);
        throttle_slots = SLOT_W'(1);
        cta_done = '0; cta_done[0] = 1'b1; disp_ready = 1;
        step();
        chk(s_valid == 0, "R4", "lowered throttle blocks refill", s_valid, 0);
        cta_done = '0;
        random_run(40, 1);
        // R11: start while running is ignored
        kern_num_ctas = CTA_W'(5); start = 1; disp_ready = 1;
        step();
        start = 0;
        throttle_slots = SLOT_W'(12);
        random_run(4000, 1);
        step();
        chk(kernel_done == 1, "R11", "mid-run start ignored, kernel finished", kernel_done, 1);
        chk(fires == 40, "R11", "total dispatched C", fires, 40);

        // Scenario D: error then empty kernel
        throttle_slots = SLOT_W'(8);
        for (int i = 0; i < NC; i++) begin regt[i] = 60; smt[i] = 1000; end
        drive_totals();
        launch(10, 100, 1);
        disp_ready = 1;
        step(); step();
        chk(kernel_err == 1, "R10", "error raised", kernel_err, 1);
        chk(disp_valid == 0, "R10", "no offer in error", disp_valid, 0);
        launch(0, 20, 1);
        step(); step();
        chk(kernel_done == 1, "R9", "empty kernel done", kernel_done, 1);
        chk(kernel_err == 0, "R10", "error cleared by restart", kernel_err, 0);

        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: run did not finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule